// File: doc/BRIEF.md
# SPI Transfer Queue and Register Layer

This block is the bus-facing half of an SPI master. A simple request/acknowledge register port exposes three words: a data word that launches transfers, a transfer-setup word (chip-select mask, write bit count, read bit count) and a configuration word (mode flags, clock dividers and live status). A bit-level shift engine sits behind the block. The block hands it a start pulse together with the transmit word and the two bit counts. The engine answers with a one-cycle done pulse carrying the received word.

Writing the data word places it in a one-entry holding buffer. The buffered word is launched as soon as the engine is idle. If a transfer is already running, the word waits and launches in the cycle after the running transfer's done pulse, so chip select stays asserted across the chain. Setup writes are shadowed and latched only when a transfer launches. Configuration writes act on the next cycle. The block drives the chip-select lines at the configured polarity and an output-enable that is low while the interface is marked offline.

Top module: `spi_txn_queue`

## Requirements
- R1: After reset no chip-select line is asserted (all `sel_n` high), the setup word reads 0, and the configuration word reads 0x00000001 (offline set, every other field 0).
- R2: With the holding buffer empty, a data write is acknowledged in the first clock edge after the request is presented.
- R3: A buffered word launches with a one-cycle `eng_start` pulse one cycle after it was buffered when the engine is idle, presenting the buffered word on `eng_tx`.
- R4: A word buffered while a transfer runs launches in the cycle after that transfer's done pulse, and chip select stays asserted with no idle cycle between the chained transfers.
- R5: A data write presented while the holding buffer is occupied is not acknowledged until the buffer has drained into the engine.
- R6: Chip select is asserted from the launch cycle and released in the cycle after done when nothing is pending.
- R7: Setup word (address 1) layout: bits 15:0 chip-select mask, 23:16 write bit count, 31:24 read bit count; a setup write changes neither the running transfer nor the chip-select lines, and is applied at the next launch.
- R8: Configuration word (address 2) layout: bit 3 chip-select polarity (0 means active low), bit 4 clock idle level, bit 5 clock phase, bit 6 LSB first, bit 7 single-wire mode, bits 23:16 write divider minus 2, bits 31:24 read divider minus 2; writes take effect on the next cycle.
- R9: Reading the data word (address 0) returns the received word of the most recently completed transfer.
- R10: Configuration reads report status in bit 0 (offline), bit 1 (transfer running) and bit 2 (buffer occupied); bits 1 and 2 ignore writes.
- R11: `pins_oe` is low while the offline bit is set and high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_stb | input | 1 | Register request, held until acknowledged |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_adr | input | 2 | Register address: 0 data, 1 setup, 2 configuration |
| bus_wdat | input | 32 | Write data |
| bus_ack | output | 1 | One-cycle acknowledge |
| bus_rdat | output | 32 | Read data, valid with acknowledge |
| eng_start | output | 1 | One-cycle launch pulse to the shift engine |
| eng_tx | output | 32 | Word to shift out |
| eng_wbits | output | 8 | Write bit count of the launched transfer |
| eng_rbits | output | 8 | Read bit count of the launched transfer |
| eng_done | input | 1 | One-cycle completion pulse from the engine |
| eng_rx | input | 32 | Received word, valid with done |
| mode_clk_pol | output | 1 | Clock idle level |
| mode_clk_phase | output | 1 | Clock sampling phase |
| mode_lsb_first | output | 1 | Bit order |
| mode_half_duplex | output | 1 | Single-wire data mode |
| wr_div_m2 | output | 8 | Write clock divider minus 2 |
| rd_div_m2 | output | 8 | Read clock divider minus 2 |
| pins_oe | output | 1 | Output enable for the interface pins |
| sel_n | output | NCS | Chip-select lines at configured polarity |

## Verification
The bench issues a lone transfer on an idle engine, which separates the idle-launch path from the chained one. It then queues two more words behind a running transfer, so the buffer is empty for one write and full for the next; this exposes both the immediate and the withheld acknowledge and shows whether chip select drops between links. A setup write made mid-transfer tells a shadowed setup apart from one applied at once. A polarity flip and an offline toggle, with a long transfer running, separate the immediate configuration path and the live status bits from the queued state.

// File: rtl/spi_q_pkg.sv
package spi_q_pkg;
    localparam int WORD_W = 32;
    localparam int LEN_W  = 8;
    localparam int MASK_W = 16;

    typedef enum logic [1:0] {
        A_DATA = 2'd0,
        A_XFER = 2'd1,
        A_CFG  = 2'd2,
        A_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [LEN_W-1:0] rdiv;
        logic [LEN_W-1:0] wdiv;
        logic             half_dup;
        logic             lsb_first;
        logic             clk_phase;
        logic             clk_pol;
        logic             cs_pol;
        logic             offline;
    } cfg_t;

    typedef struct packed {
        logic [LEN_W-1:0]  rlen;
        logic [LEN_W-1:0]  wlen;
        logic [MASK_W-1:0] cs_mask;
    } xfer_t;

    function automatic logic [WORD_W-1:0] cfg_word(cfg_t c, logic act, logic pend);
        return {c.rdiv, c.wdiv, 8'h00, c.half_dup, c.lsb_first, c.clk_phase,
                c.clk_pol, c.cs_pol, pend, act, c.offline};
    endfunction

    function automatic cfg_t cfg_from_word(logic [WORD_W-1:0] w);
        cfg_t c;
        c.rdiv      = w[31:24];
        c.wdiv      = w[23:16];
        c.half_dup  = w[7];
        c.lsb_first = w[6];
        c.clk_phase = w[5];
        c.clk_pol   = w[4];
        c.cs_pol    = w[3];
        c.offline   = w[0];
        return c;
    endfunction
endpackage

// File: rtl/spi_q_regs.sv
module spi_q_regs
    import spi_q_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_stb,
    input  logic              bus_we,
    input  logic [1:0]        bus_adr,
    input  logic [WORD_W-1:0] bus_wdat,
    output logic              bus_ack,
    output logic [WORD_W-1:0] bus_rdat,
    input  logic              active_i,
    input  logic              pending_i,
    input  logic [WORD_W-1:0] rx_i,
    output logic              data_wr_o,
    output cfg_t              cfg_o,
    output xfer_t             xfer_o
);
    typedef struct packed {
        logic              ack;
        logic [WORD_W-1:0] rdat;
        cfg_t              cfg;
        xfer_t             xsh;
    } st_t;

    st_t       st_q, st_d;
    reg_addr_e adr_w;
    logic      accept_w;
    logic      hit_w;

    always_comb begin
        adr_w    = reg_addr_e'(bus_adr);
        // a data write into a full buffer waits without acknowledge
        accept_w = !(bus_we && adr_w == A_DATA && pending_i);
        hit_w    = bus_stb && !st_q.ack && accept_w;
        st_d     = st_q;
        st_d.ack = hit_w;
        if (hit_w && !bus_we) begin
            case (adr_w)
                A_DATA:  st_d.rdat = rx_i;
                A_XFER:  st_d.rdat = st_q.xsh;
                A_CFG:   st_d.rdat = cfg_word(st_q.cfg, active_i, pending_i);
                default: st_d.rdat = '0;
            endcase
        end
        if (hit_w && bus_we) begin
            case (adr_w)
                A_XFER:  st_d.xsh = xfer_t'(bus_wdat);
                A_CFG:   st_d.cfg = cfg_from_word(bus_wdat);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q             <= '0;
            st_q.cfg.offline <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_wr_o = hit_w && bus_we && (adr_w == A_DATA);
    assign bus_ack   = st_q.ack;
    assign bus_rdat  = st_q.rdat;
    assign cfg_o     = st_q.cfg;
    assign xfer_o    = st_q.xsh;

    // R5: full buffer withholds the acknowledge
    p_hold_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stb && bus_we && bus_adr == 2'd0 && pending_i) |=> !bus_ack);
endmodule

// File: rtl/spi_q_launch.sv
module spi_q_launch
    import spi_q_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_wr_i,
    input  logic [WORD_W-1:0] data_i,
    input  xfer_t             xfer_i,
    input  logic              eng_done_i,
    input  logic [WORD_W-1:0] eng_rx_i,
    output logic              start_o,
    output logic [WORD_W-1:0] tx_o,
    output xfer_t             cur_o,
    output logic              active_o,
    output logic              pending_o,
    output logic [WORD_W-1:0] rx_o
);
    typedef struct packed {
        logic              pend;
        logic [WORD_W-1:0] hold;
        logic              act;
        logic              start;
        xfer_t             cur;
        logic [WORD_W-1:0] tx;
        logic [WORD_W-1:0] rx;
    } st_t;

    st_t  st_q, st_d;
    logic done_w;
    logic launch_w;

    always_comb begin
        done_w   = eng_done_i && st_q.act;
        // idle launch, or chained launch on the done edge
        launch_w = st_q.pend && (!st_q.act || done_w);
        st_d       = st_q;
        st_d.start = launch_w;
        if (launch_w) begin
            st_d.cur = xfer_i;
            st_d.tx  = st_q.hold;
            st_d.act = 1'b1;
        end else if (done_w) begin
            st_d.act = 1'b0;
        end
        if (data_wr_i) begin
            st_d.pend = 1'b1;
            st_d.hold = data_i;
        end else if (launch_w) begin
            st_d.pend = 1'b0;
        end
        if (done_w) begin
            st_d.rx = eng_rx_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign start_o   = st_q.start;
    assign tx_o      = st_q.tx;
    assign cur_o     = st_q.cur;
    assign active_o  = st_q.act;
    assign pending_o = st_q.pend;
    assign rx_o      = st_q.rx;

    // R3: every launch comes from an occupied buffer
    p_start_from_buf_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.start |-> $past(st_q.pend));
    // R4: done with a word waiting keeps the transfer running and relaunches
    p_chain_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act && eng_done_i && st_q.pend) |=> (st_q.act && st_q.start));
    // R6: done with nothing waiting ends the transfer
    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act && eng_done_i && !st_q.pend) |=> !st_q.act);
    // R7: running parameters hold between launches
    p_setup_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act && !(eng_done_i && st_q.pend)) |=> $stable(st_q.cur));
endmodule

// File: rtl/spi_q_csdrv.sv
module spi_q_csdrv #(
    parameter int NCS = 16
) (
    input  logic           active_i,
    input  logic [NCS-1:0] mask_i,
    input  logic           cs_pol_i,
    input  logic           offline_i,
    output logic [NCS-1:0] sel_n_o,
    output logic           pins_oe_o
);
    for (genvar g = 0; g < NCS; g++) begin : g_line
        assign sel_n_o[g] = (active_i && mask_i[g]) ? cs_pol_i : ~cs_pol_i;
    end
    assign pins_oe_o = ~offline_i;
endmodule

// File: rtl/spi_txn_queue.sv
module spi_txn_queue
    import spi_q_pkg::*;
#(
    parameter int NCS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_stb,
    input  logic              bus_we,
    input  logic [1:0]        bus_adr,
    input  logic [WORD_W-1:0] bus_wdat,
    output logic              bus_ack,
    output logic [WORD_W-1:0] bus_rdat,
    output logic              eng_start,
    output logic [WORD_W-1:0] eng_tx,
    output logic [LEN_W-1:0]  eng_wbits,
    output logic [LEN_W-1:0]  eng_rbits,
    input  logic              eng_done,
    input  logic [WORD_W-1:0] eng_rx,
    output logic              mode_clk_pol,
    output logic              mode_clk_phase,
    output logic              mode_lsb_first,
    output logic              mode_half_duplex,
    output logic [LEN_W-1:0]  wr_div_m2,
    output logic [LEN_W-1:0]  rd_div_m2,
    output logic              pins_oe,
    output logic [NCS-1:0]    sel_n
);
    logic              data_wr_w;
    logic              active_w;
    logic              pending_w;
    logic [WORD_W-1:0] rx_w;
    cfg_t              cfg_w;
    xfer_t             xsh_w;
    xfer_t             cur_w;

    spi_q_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_stb   (bus_stb),
        .bus_we    (bus_we),
        .bus_adr   (bus_adr),
        .bus_wdat  (bus_wdat),
        .bus_ack   (bus_ack),
        .bus_rdat  (bus_rdat),
        .active_i  (active_w),
        .pending_i (pending_w),
        .rx_i      (rx_w),
        .data_wr_o (data_wr_w),
        .cfg_o     (cfg_w),
        .xfer_o    (xsh_w)
    );

    spi_q_launch u_launch (
        .clk        (clk),
        .rst_n      (rst_n),
        .data_wr_i  (data_wr_w),
        .data_i     (bus_wdat),
        .xfer_i     (xsh_w),
        .eng_done_i (eng_done),
        .eng_rx_i   (eng_rx),
        .start_o    (eng_start),
        .tx_o       (eng_tx),
        .cur_o      (cur_w),
        .active_o   (active_w),
        .pending_o  (pending_w),
        .rx_o       (rx_w)
    );

    spi_q_csdrv #(.NCS(NCS)) u_cs (
        .active_i  (active_w),
        .mask_i    (cur_w.cs_mask[NCS-1:0]),
        .cs_pol_i  (cfg_w.cs_pol),
        .offline_i (cfg_w.offline),
        .sel_n_o   (sel_n),
        .pins_oe_o (pins_oe)
    );

    assign eng_wbits        = cur_w.wlen;
    assign eng_rbits        = cur_w.rlen;
    assign mode_clk_pol     = cfg_w.clk_pol;
    assign mode_clk_phase   = cfg_w.clk_phase;
    assign mode_lsb_first   = cfg_w.lsb_first;
    assign mode_half_duplex = cfg_w.half_dup;
    assign wr_div_m2        = cfg_w.wdiv;
    assign rd_div_m2        = cfg_w.rdiv;
endmodule

// File: tb/sim_spi_txn_queue.sv
module sim_spi_txn_queue;
    localparam int NCS = 16;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    logic bus_stb = 1'b0, bus_we = 1'b0;
    logic [1:0] bus_adr = '0;
    logic [31:0] bus_wdat = '0;
    logic bus_ack;
    logic [31:0] bus_rdat;
    logic eng_start;
    logic [31:0] eng_tx;
    logic [7:0] eng_wbits, eng_rbits;
    logic eng_done = 1'b0;
    logic [31:0] eng_rx = '0;
    logic mode_clk_pol, mode_clk_phase, mode_lsb_first, mode_half_duplex;
    logic [7:0] wr_div_m2, rd_div_m2;
    logic pins_oe;
    logic [NCS-1:0] sel_n;

    spi_txn_queue #(.NCS(NCS)) u0 (.*);

    int tests = 0, fails = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // behavioural shift engine: done after wbits+rbits+2 cycles, echoes ~tx
    int eng_cnt = 0, n_done = 0, gaps = 0;
    logic [31:0] eng_cap = '0;
    bit chain_win = 0;
    always @(negedge clk) begin
        if (chain_win && sel_n == '1) gaps++;
        eng_done = 1'b0;
        if (eng_cnt > 0) begin
            eng_cnt--;
            if (eng_cnt == 0) begin
                eng_done = 1'b1;
                eng_rx   = ~eng_cap;
                n_done++;
            end
        end
        if (eng_start) begin
            eng_cnt = int'(eng_wbits) + int'(eng_rbits) + 2;
            eng_cap = eng_tx;
        end
    end

    // reference model
    bit m_ack, m_rd, m_pend, m_act, m_start;
    bit m_off, m_pol, m_cpol, m_cpha, m_lsb, m_hd;
    logic [31:0] m_rdat, m_hold, m_tx, m_rx, m_xsh;
    logic [15:0] m_cs;
    logic [7:0] m_wl, m_rl, m_wd, m_rdv;

    always @(posedge clk) begin
        bit acc, hit, done, launch;
        if (!rst_n) begin
            m_ack = 0; m_rd = 0; m_pend = 0; m_act = 0; m_start = 0;
            m_off = 1; m_pol = 0; m_cpol = 0; m_cpha = 0; m_lsb = 0; m_hd = 0;
            m_rdat = 0; m_hold = 0; m_tx = 0; m_rx = 0; m_xsh = 0;
            m_cs = 0; m_wl = 0; m_rl = 0; m_wd = 0; m_rdv = 0;
        end else begin
            acc    = !(bus_stb && bus_we && bus_adr == 2'd0 && m_pend);
            hit    = bus_stb && !m_ack && acc;
            done   = eng_done && m_act;
            launch = m_pend && (!m_act || done);
            m_rd   = hit && !bus_we;
            if (m_rd) begin
                case (bus_adr)
                    2'd0: m_rdat = m_rx;
                    2'd1: m_rdat = m_xsh;
                    2'd2: m_rdat = {m_rdv, m_wd, 8'h00, m_hd, m_lsb, m_cpha,
                                    m_cpol, m_pol, m_pend, m_act, m_off};
                    default: m_rdat = 0;
                endcase
            end
            if (launch) begin
                m_cs = m_xsh[15:0]; m_wl = m_xsh[23:16]; m_rl = m_xsh[31:24];
                m_tx = m_hold; m_act = 1;
            end else if (done) m_act = 0;
            m_start = launch;
            if (hit && bus_we && bus_adr == 2'd0) begin
                m_pend = 1; m_hold = bus_wdat;
            end else if (launch) m_pend = 0;
            if (done) m_rx = eng_rx;
            if (hit && bus_we && bus_adr == 2'd1) m_xsh = bus_wdat;
            if (hit && bus_we && bus_adr == 2'd2) begin
                m_rdv = bus_wdat[31:24]; m_wd = bus_wdat[23:16];
                m_hd = bus_wdat[7]; m_lsb = bus_wdat[6]; m_cpha = bus_wdat[5];
                m_cpol = bus_wdat[4]; m_pol = bus_wdat[3]; m_off = bus_wdat[0];
            end
            m_ack = hit;
        end
    end

    always @(negedge clk) begin
        logic [NCS-1:0] exp_sel;
        if (rst_n) begin
            chk(bus_ack == m_ack, "R5", "acknowledge", 64'(bus_ack), 64'(m_ack));
            if (m_ack && m_rd) chk(bus_rdat == m_rdat, "R9", "read data", 64'(bus_rdat), 64'(m_rdat));
            chk(eng_start == m_start, "R3", "start pulse", 64'(eng_start), 64'(m_start));
            if (m_start)
                chk({eng_tx, eng_wbits, eng_rbits} == {m_tx, m_wl, m_rl}, "R7", "launch params",
                    64'({eng_tx, eng_wbits, eng_rbits}), 64'({m_tx, m_wl, m_rl}));
            for (int i = 0; i < NCS; i++) exp_sel[i] = (m_act && m_cs[i]) ? m_pol : !m_pol;
            chk(sel_n == exp_sel, "R6", "chip select", 64'(sel_n), 64'(exp_sel));
            chk(pins_oe == !m_off, "R11", "output enable", 64'(pins_oe), 64'(!m_off));
            chk({mode_clk_pol, mode_clk_phase, mode_lsb_first, mode_half_duplex, wr_div_m2, rd_div_m2}
                == {m_cpol, m_cpha, m_lsb, m_hd, m_wd, m_rdv}, "R8", "mode outputs",
                64'({mode_clk_pol, mode_clk_phase, mode_lsb_first, mode_half_duplex, wr_div_m2, rd_div_m2}),
                64'({m_cpol, m_cpha, m_lsb, m_hd, m_wd, m_rdv}));
        end
    end

    task automatic bus(input bit we, input logic [1:0] a, input logic [31:0] d,
                       output logic [31:0] r, output int waitc);
        @(negedge clk);
        bus_stb = 1; bus_we = we; bus_adr = a; bus_wdat = d; waitc = 0;
        do begin
            @(negedge clk);
            waitc++;
        end while (!bus_ack);
        r = bus_rdat; bus_stb = 0; bus_we = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] r, cfg;
        int w, base;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(sel_n == '1, "R1", "idle select after reset", 64'(sel_n), 64'hffff);
        chk(pins_oe == 0, "R11", "offline after reset", 64'(pins_oe), 0);
        bus(0, 2'd2, 0, r, w);
        chk(r == 32'h1, "R10", "config after reset", 64'(r), 1);
        bus(0, 2'd1, 0, r, w);
        chk(r == 0, "R1", "setup after reset", 64'(r), 0);

        cfg = (32'd5 << 24) | (32'd3 << 16) | 32'h10;
        bus(1, 2'd2, cfg, r, w);
        @(negedge clk);
        chk(mode_clk_pol == 1 && wr_div_m2 == 3 && rd_div_m2 == 5, "R8", "config immediate",
            64'({mode_clk_pol, wr_div_m2, rd_div_m2}), 64'({1'b1, 8'd3, 8'd5}));
        chk(pins_oe == 1, "R11", "online", 64'(pins_oe), 1);

        bus(1, 2'd1, (32'd4 << 24) | (32'd8 << 16) | 32'h5, r, w);
        chk(sel_n == '1, "R7", "setup write selects nothing", 64'(sel_n), 64'hffff);

        base = n_done;
        bus(1, 2'd0, 32'hA5A5_0001, r, w);
        chk(w == 1, "R2", "data ack latency", 64'(w), 1);
        wait (n_done == base + 1);
        repeat (3) @(negedge clk);
        chk(sel_n == '1, "R6", "released after lone transfer", 64'(sel_n), 64'hffff);
        bus(0, 2'd0, 0, r, w);
        chk(r == ~32'hA5A5_0001, "R9", "received word", 64'(r), 64'(~32'hA5A5_0001));

        base = n_done; gaps = 0;
        bus(1, 2'd0, 32'h1111_0001, r, w);
        bus(1, 2'd1, (32'd6 << 24) | (32'd6 << 16) | 32'h2, r, w);
        chk(sel_n == ~16'h0005, "R7", "running select unchanged", 64'(sel_n), 64'(~16'h0005));
        chain_win = 1;
        bus(1, 2'd0, 32'h2222_0002, r, w);
        chk(w == 1, "R2", "ack with empty buffer during transfer", 64'(w), 1);
        bus(1, 2'd0, 32'h3333_0003, r, w);
        chk(w > 3, "R5", "ack withheld while buffer full", 64'(w), 4);
        bus(0, 2'd2, 0, r, w);
        chk(r[2:0] == 3'b110, "R10", "status while chained", 64'(r[2:0]), 6);
        wait (n_done == base + 3);
        chain_win = 0;
        chk(gaps == 0, "R4", "select gaps in chain", 64'(gaps), 0);
        repeat (3) @(negedge clk);
        chk(sel_n == '1, "R6", "released after chain", 64'(sel_n), 64'hffff);
        bus(0, 2'd0, 0, r, w);
        chk(r == ~32'h3333_0003, "R9", "last chained word", 64'(r), 64'(~32'h3333_0003));
        bus(0, 2'd2, 0, r, w);
        chk(r[2:0] == 0, "R10", "status idle", 64'(r[2:0]), 0);

        cfg = cfg | 32'h8;
        bus(1, 2'd2, cfg | 32'h6, r, w);
        @(negedge clk);
        chk(sel_n == '0, "R8", "polarity flips idle level", 64'(sel_n), 0);
        bus(0, 2'd2, 0, r, w);
        chk(r[2:0] == 0, "R10", "status ignores writes", 64'(r[2:0]), 0);
        bus(1, 2'd1, (32'd200 << 16) | 32'h2, r, w);
        base = n_done;
        bus(1, 2'd0, 32'h0F0F_0F0F, r, w);
        repeat (2) @(negedge clk);
        chk(sel_n == 16'h0002, "R8", "active-high select", 64'(sel_n), 2);
        bus(1, 2'd2, cfg | 32'h1, r, w);
        @(negedge clk);
        chk(pins_oe == 0, "R11", "offline again", 64'(pins_oe), 0);
        wait (n_done == base + 1);
        repeat (3) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule